// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received Ethernet frames in a circular buffer held in local packet RAM. The buffer is organised in 256-byte pages. Frames arrive as a byte stream that has already passed address filtering. Each frame is placed at the start of the current page. It is preceded by a 4-byte descriptor that gives its status, the page where the next frame will start, and its stored length. Short frames are padded with zeros to the minimum length, and over-long frames are cut to the maximum length. After the descriptor is written, the current-page pointer moves on to the next frame's page and a one-cycle completion pulse is raised.

The ring lies between a start page and a stop page. The stop page is exclusive. A host-owned boundary page marks how far software has consumed the ring. Before a new frame is started, the block checks whether the ring still has room for a worst-case frame. If the receiver is stopped or the ring is full, the frame is drained from the stream and nothing is written. The host may overwrite the current page at any time. A frame that is already in progress keeps the base page it latched when it started.

The frame input is valid/ready. A byte moves when both `in_valid` and `in_ready` are high at a clock edge. `in_ready` is high while the block is idle, while it is storing payload, and while it is discarding a dropped frame. It is low while the block writes padding and the descriptor. During those cycles the sender must hold its next byte, which may be the first byte of a new frame, until ready returns. Bytes that arrive while idle without the first-byte marker are accepted and discarded.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `in_ready` is 1, `mem_we` is 0, `rx_done` is 0 and `cur_pg` is 0.
- R2: The payload of a stored frame is written in arrival order, one byte per write. The first byte goes to address cur_pg*256+4. Exactly (padded length + 4) RAM writes are made per stored frame.
- R3: A frame shorter than 60 bytes is followed by zero bytes until 60 payload bytes are stored. The stored length field covers the padding.
- R4: The descriptor occupies bytes 0..3 of the frame's base page. Byte 0 is the status: 0x01, or 0x21 when bit 0 of the first frame byte is 1. Byte 1 is the next-frame page. Byte 2 is the low byte of (payload length + 4) and byte 3 is the high byte.
- R5: next page = base + ceil((payload length + 8) / 256). When that is at or above the stop page, (stop - start) is subtracted.
- R6: A payload write address that would reach stop*256 continues at start*256.
- R7: `ring_full` is 1 when the free pages are fewer than 6. Free pages are (bnd - cur) when cur < bnd, and (stop - start) - (cur - bnd) otherwise. A frame whose first byte arrives while `ring_full` is 1 causes no RAM write and no pointer change.
- R8: A frame whose first byte arrives while `rx_stopped` is 1 causes no RAM write, no `rx_done` and no pointer change.
- R9: One cycle after the last descriptor write, `rx_done` pulses for exactly one cycle and `cur_pg` equals the next-frame page.
- R10: Payload bytes beyond 1514 are accepted from the stream but not stored. The stored length is then 1518.
- R11: `in_ready` is 0 while padding or descriptor bytes are being written. A byte accepted while idle without `in_first` writes nothing.
- R12: A pulse on `cur_wr_en` loads `cur_wr_pg` into `cur_pg`, visible on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_stopped | input | 1 | Receiver stopped; new frames are dropped |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page one past the end of the ring |
| bnd_pg | input | 8 | Host boundary page |
| cur_wr_en | input | 1 | Host write strobe for the current page |
| cur_wr_pg | input | 8 | Value for the current page |
| cur_pg | output | 8 | Current page pointer |
| ring_full | output | 1 | Fewer than a worst-case frame's pages are free |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block accepts a byte |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| rx_done | output | 1 | Frame stored pulse |

## Verification
The hardest situation to reach is a frame whose payload crosses the stop page in mid-frame while its next-page value also wraps. The stimulus creates it by host-writing the current page two pages below the stop page, placing the boundary so that exactly six pages are free, and sending a 1000-byte frame. The full threshold is probed on both sides (five versus six free pages), with the boundary both above and below the current page. Seeded random frames of 1 to 1600 bytes, with idle gaps in the stream, then walk the pointer around the ring many times.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PAYLOAD,
    S_PAD,
    S_HDR,
    S_DROP
  } rxr_state_e;
endpackage

// File: rtl/rxr_space_check.sv
module rxr_space_check #(
  parameter int PG_W       = 8,
  parameter int OFF_W      = 8,
  parameter int NEED_BYTES = 1518
) (
  input  logic [PG_W-1:0] start_pg,
  input  logic [PG_W-1:0] stop_pg,
  input  logic [PG_W-1:0] bnd_pg,
  input  logic [PG_W-1:0] cur_pg,
  output logic            full
);
  localparam int SW      = PG_W + 2;
  localparam int NEED_PG = (NEED_BYTES + (1 << OFF_W) - 1) >> OFF_W;
  localparam logic signed [SW-1:0] NEED_S = SW'(NEED_PG);

  logic signed [SW-1:0] s_i, e_i, b_i, c_i, avail;

  assign s_i = $signed({2'b00, start_pg});
  assign e_i = $signed({2'b00, stop_pg});
  assign b_i = $signed({2'b00, bnd_pg});
  assign c_i = $signed({2'b00, cur_pg});

  // free pages between writer and reader, in whole pages
  always_comb begin
    if (c_i < b_i) avail = b_i - c_i;
    else           avail = (e_i - s_i) - (c_i - b_i);
  end

  assign full = (avail < NEED_S);
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8,
  parameter int LEN_W = 11,
  parameter int EXTRA = 8
) (
  input  logic [PG_W-1:0]  base_pg,
  input  logic [LEN_W-1:0] len,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [PG_W-1:0]  stop_pg,
  output logic [PG_W-1:0]  next_pg
);
  localparam int W = PG_W + LEN_W + 2;

  logic [W-1:0] span, pages, sum, ring, wrapped;

  always_comb begin
    span    = W'(len) + W'(EXTRA + (1 << OFF_W) - 1);
    pages   = span >> OFF_W;
    sum     = W'(base_pg) + pages;
    ring    = W'(stop_pg) - W'(start_pg);
    wrapped = (sum >= W'(stop_pg)) ? (sum - ring) : sum;
    next_pg = PG_W'(wrapped);
  end
endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic [PG_W+OFF_W-1:0] addr,
  input  logic [PG_W-1:0]       start_pg,
  input  logic [PG_W-1:0]       stop_pg,
  output logic [PG_W+OFF_W-1:0] nxt
);
  localparam int AW = PG_W + OFF_W;

  logic [AW-1:0] inc, stop_addr;

  assign inc       = addr + AW'(1);
  assign stop_addr = {stop_pg, {OFF_W{1'b0}}};
  assign nxt       = (inc == stop_addr) ? {start_pg, {OFF_W{1'b0}}} : inc;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PG_W    = 8,
  parameter int OFF_W   = 8,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1514,
  parameter int MIN_LEN = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_stopped,
  input  logic [PG_W-1:0]       start_pg,
  input  logic [PG_W-1:0]       stop_pg,
  input  logic [PG_W-1:0]       bnd_pg,
  input  logic                  cur_wr_en,
  input  logic [PG_W-1:0]       cur_wr_pg,
  output logic [PG_W-1:0]       cur_pg,
  output logic                  ring_full,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  in_first,
  input  logic                  in_last,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  rx_done
);
  localparam int ADDR_W     = PG_W + OFF_W;
  localparam int NEED_BYTES = MAX_LEN + HDR_BYTES;
  localparam int EXTRA      = HDR_BYTES + CRC_BYTES;
  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);
  localparam logic [OFF_W-1:0] HDR_OFF = OFF_W'(HDR_BYTES);

  rxr_state_e        state;
  logic [PG_W-1:0]   cur_pg_q, frame_pg, next_pg;
  logic [ADDR_W-1:0] wptr, pay_addr, step_nxt;
  logic [LEN_W-1:0]  len_q, len_inc, len_new;
  logic [7:0]        status_q;
  logic [1:0]        hidx;
  logic [15:0]       stored_len;
  logic [7:0]        hdr_byte [HDR_BYTES];
  logic              acc, start_ok, keep;

  rxr_space_check #(.PG_W(PG_W), .OFF_W(OFF_W), .NEED_BYTES(NEED_BYTES)) u_space (
    .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg_q),
    .full(ring_full)
  );

  rxr_next_page #(.PG_W(PG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .EXTRA(EXTRA)) u_next (
    .base_pg(frame_pg), .len(len_q), .start_pg(start_pg), .stop_pg(stop_pg),
    .next_pg(next_pg)
  );

  rxr_addr_step #(.PG_W(PG_W), .OFF_W(OFF_W)) u_step (
    .addr(pay_addr), .start_pg(start_pg), .stop_pg(stop_pg), .nxt(step_nxt)
  );

  assign cur_pg   = cur_pg_q;
  assign in_ready = (state == S_IDLE) || (state == S_PAYLOAD) || (state == S_DROP);
  assign acc      = in_valid && in_ready;
  assign start_ok = !rx_stopped && !ring_full;
  assign keep     = (len_q < MAX_L);
  assign len_inc  = len_q + ONE_L;
  assign len_new  = keep ? len_inc : len_q;
  assign pay_addr = (state == S_IDLE) ? {cur_pg_q, HDR_OFF} : wptr;
  assign stored_len = 16'(len_q) + 16'(HDR_BYTES);

  always_comb begin
    hdr_byte[0] = status_q;
    hdr_byte[1] = 8'(next_pg);
    hdr_byte[2] = stored_len[7:0];
    hdr_byte[3] = stored_len[15:8];
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = pay_addr;
    mem_wdata = in_data;
    unique case (state)
      S_IDLE:    mem_we = acc && in_first && start_ok;
      S_PAYLOAD: mem_we = acc && keep;
      S_PAD: begin
        mem_we    = 1'b1;
        mem_wdata = 8'h00;
      end
      S_HDR: begin
        mem_we    = 1'b1;
        mem_addr  = {frame_pg, OFF_W'(hidx)};
        mem_wdata = hdr_byte[hidx];
      end
      default: mem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_pg_q <= '0;
      frame_pg <= '0;
      wptr     <= '0;
      len_q    <= '0;
      status_q <= '0;
      hidx     <= '0;
      rx_done  <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (cur_wr_en) cur_pg_q <= cur_wr_pg;
      unique case (state)
        S_IDLE: begin
          hidx <= '0;
          if (acc && in_first) begin
            if (start_ok) begin
              frame_pg <= cur_pg_q;
              status_q <= 8'h01 | {2'b00, in_data[0], 5'b00000};
              len_q    <= ONE_L;
              wptr     <= step_nxt;
              if (in_last) state <= (ONE_L < MIN_L) ? S_PAD : S_HDR;
              else         state <= S_PAYLOAD;
            end else if (!in_last) begin
              state <= S_DROP;
            end
          end
        end
        S_PAYLOAD: begin
          if (acc) begin
            if (keep) begin
              len_q <= len_inc;
              wptr  <= step_nxt;
            end
            if (in_last) state <= (len_new < MIN_L) ? S_PAD : S_HDR;
          end
        end
        S_PAD: begin
          len_q <= len_inc;
          wptr  <= step_nxt;
          if (len_inc >= MIN_L) state <= S_HDR;
        end
        S_HDR: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            state    <= S_IDLE;
            cur_pg_q <= next_pg;
            rx_done  <= 1'b1;
          end
        end
        S_DROP: if (acc && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: a frame start seen while stopped never enters a storing state
  assert_stopped_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && in_valid && in_first && rx_stopped) |=>
      (state == S_IDLE || state == S_DROP));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R9: pointer lands on the page computed for the finished frame
  assert_cur_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (cur_pg_q == $past(next_pg)));

  // R10: stored payload never exceeds the cap
  assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= MAX_L);

  // R3: the descriptor is only written once the minimum length is stored
  assert_hdr_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HDR) |-> (len_q >= MIN_L));

  // R6: payload writes of an in-ring frame stay inside the ring
  assert_payload_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (state == S_PAYLOAD || state == S_PAD) && start_pg < stop_pg &&
     frame_pg >= start_pg && frame_pg < stop_pg) |->
      (mem_addr >= {start_pg, {OFF_W{1'b0}}} && mem_addr < {stop_pg, {OFF_W{1'b0}}}));
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_stopped;
  logic [7:0]  start_pg, stop_pg, bnd_pg;
  logic        cur_wr_en;
  logic [7:0]  cur_wr_pg;
  logic [7:0]  cur_pg;
  logic        ring_full;
  logic        in_valid, in_ready, in_first, in_last;
  logic [7:0]  in_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rx_done;

  int checks = 0;
  int fails  = 0;
  int wcnt   = 0;
  int dcnt   = 0;
  int cyc    = 0;
  logic [7:0] mm [int];
  logic [7:0] fr [0:2047];
  int unsigned seed_junk;

  always #4 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_stopped(rx_stopped),
    .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
    .cur_wr_en(cur_wr_en), .cur_wr_pg(cur_wr_pg), .cur_pg(cur_pg), .ring_full(ring_full),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_done(rx_done)
  );

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      mm[int'(mem_addr)] = mem_wdata;
      wcnt++;
    end
    if (rst_n && rx_done) dcnt++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp below 180000)", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    return mm.exists(a) ? int'(mm[a]) : -1;
  endfunction

  function automatic int exp_next(input int base, input int plen);
    int s = (plen < 60) ? 60 : plen;
    int n = base + (s + 8 + 255) / 256;
    if (n >= int'(stop_pg)) n -= int'(stop_pg) - int'(start_pg);
    return n;
  endfunction

  function automatic bit exp_full(input int c, input int b);
    int av = (c < b) ? (b - c) : (int'(stop_pg) - int'(start_pg)) - (c - b);
    return av < 6;
  endfunction

  task automatic push(input logic [7:0] d, input logic f, input logic l);
    logic r;
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
    do begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!r);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic set_cur(input logic [7:0] p);
    cur_wr_en = 1'b1; cur_wr_pg = p;
    @(negedge clk);
    cur_wr_en = 1'b0;
  endtask

  task automatic send(input int len, input bit grp, input bit gaps);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    fr[0][0] = grp;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      push(fr[i], i == 0, i == len - 1);
    end
  endtask

  task automatic prep();
    mm.delete();
    wcnt = 0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 400 && dcnt == d0; i++) @(negedge clk);
    check("R9", "rx_done pulses", dcnt - d0, 1);
  endtask

  task automatic verify(input int base, input int len, input bit grp);
    int plen = (len > 1514) ? 1514 : len;
    int slen = (plen < 60) ? 60 : plen;
    int nx   = exp_next(base, plen);
    int a    = base * 256 + 4;
    int bad_pay = 0;
    int bad_pad = 0;
    check("R4", "status byte", rd(base * 256), grp ? 8'h21 : 8'h01);
    check("R5", "next page byte", rd(base * 256 + 1), nx);
    check("R4", "stored length", rd(base * 256 + 2) | (rd(base * 256 + 3) << 8), slen + 4);
    for (int i = 0; i < slen; i++) begin
      if (i < plen) begin
        if (rd(a) != int'(fr[i])) bad_pay++;
      end else begin
        if (rd(a) != 0) bad_pad++;
      end
      a++;
      if (a == int'(stop_pg) * 256) a = int'(start_pg) * 256;
    end
    check("R2", "payload byte mismatches", bad_pay, 0);
    if (plen < 60) check("R3", "pad byte mismatches", bad_pad, 0);
    check((len > 1514) ? "R10" : "R2", "write count", wcnt, slen + 4);
    check("R9", "cur_pg after frame", int'(cur_pg), nx);
  endtask

  task automatic frame(input int len, input bit grp, input bit gaps);
    int base = int'(cur_pg);
    int d0 = dcnt;
    prep();
    send(len, grp, gaps);
    wait_done(d0);
    verify(base, len, grp);
  endtask

  initial begin
    int d0;
    int base;
    seed_junk = $urandom(32'h1357_9bdf);
    rst_n = 1'b0; rx_stopped = 1'b0;
    start_pg = 8'h40; stop_pg = 8'h80; bnd_pg = 8'h40;
    cur_wr_en = 1'b0; cur_wr_pg = '0;
    in_valid = 1'b0; in_data = '0; in_first = 1'b0; in_last = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "in_ready", in_ready, 1);
    check("R1", "mem_we", mem_we, 0);
    check("R1", "rx_done", rx_done, 0);
    check("R1", "cur_pg", cur_pg, 0);

    // R12 host write of the current page
    set_cur(8'h40);
    check("R12", "cur_pg after host write", cur_pg, 8'h40);
    bnd_pg = cur_pg;

    // R11 + R3: short frame, ready drops during padding
    base = int'(cur_pg); d0 = dcnt; prep();
    send(10, 1'b0, 1'b0);
    check("R11", "in_ready while padding", in_ready, 0);
    wait_done(d0);
    verify(base, 10, 1'b0);

    // directed lengths
    frame(1, 1'b1, 1'b0);
    frame(60, 1'b1, 1'b0);
    frame(61, 1'b0, 1'b1);
    frame(1514, 1'b0, 1'b0);
    frame(1520, 1'b1, 1'b0);   // R10 truncation

    // R11 stray byte in idle without first marker
    prep();
    push(8'h5a, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R11", "writes from stray byte", wcnt, 0);

    // R8 stopped receiver
    rx_stopped = 1'b1; base = int'(cur_pg); d0 = dcnt; prep();
    send(20, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check("R8", "writes while stopped", wcnt, 0);
    check("R8", "done while stopped", dcnt - d0, 0);
    check("R8", "cur_pg while stopped", cur_pg, base);
    rx_stopped = 1'b0;

    // R7 full threshold, cur below boundary
    set_cur(8'h46); bnd_pg = 8'h4b;
    @(negedge clk);
    check("R7", "full at 5 free pages", ring_full, 1);
    d0 = dcnt; prep();
    send(20, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check("R7", "writes while full", wcnt, 0);
    check("R7", "cur_pg while full", cur_pg, 8'h46);
    bnd_pg = 8'h4c;
    @(negedge clk);
    check("R7", "not full at 6 free pages", ring_full, 0);

    // R7 with cur above boundary
    set_cur(8'h7e); bnd_pg = 8'h43;
    @(negedge clk);
    check("R7", "full cur>bnd", ring_full, exp_full(8'h7e, 8'h43));
    bnd_pg = 8'h44;
    @(negedge clk);
    check("R7", "not full cur>bnd", ring_full, exp_full(8'h7e, 8'h44));

    // R6 payload and next page both wrap
    frame(1000, 1'b0, 1'b1);
    check("R6", "wrapped next page", cur_pg, 8'h42);

    // random frames, ring kept empty
    for (int k = 0; k < 30; k++) begin
      bnd_pg = cur_pg;
      frame(int'($urandom_range(1, 1600)), 1'($urandom), 1'b1);
    end

    summary();
    $finish;
  end
endmodule